// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. Software programs two registers. The control register sets the word length, the stop-bit setting and one of sixteen bit rates. The command register sets the parity scheme, the transmitter mode, interrupt masking and a data-terminal-ready pin. Software reads the status register to learn whether the transmit holding register can take another byte. It can also see there whether an interrupt is pending. Writing any value to the status address performs a programmed reset.

Bytes enter through a one-deep holding register, and the transmitter moves each byte into its shift register when the shift register is idle. The bit rate comes from the block clock, which is taken to be a 1.2288 MHz reference by default. Each bit lasts sixteen rate ticks, and the rate divider restarts at the beginning of every frame.

A data write is always accepted: the register interface has no back-pressure. If the holding register is still full, the new byte replaces the old one. Software must therefore wait for the empty flag, or for the interrupt, before it writes the next byte.

Top module: `ser_tx_top`

## Requirements
- R1: After hardware reset, txd, irq_n, rts_n and dtr_n are all 1. A read of address 0 (status) returns 8'h10 and a read of any other address returns 8'h00.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. The number of data bits is set by control bits [6:5]: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Byte bits above the word length are not sent.
- R3: Parity is on when command bit 5 is 1, and command bits [7:6] then choose the kind: 00 is odd, 01 is even, 10 is a constant 1 and 11 is a constant 0. With command bit 5 at 0, no parity bit is sent.
- R4: The stop interval is 1 bit when control bit 7 is 0. When control bit 7 is 1 it is 1.5 bits for a 5-bit word, 1 bit for an 8-bit word with parity, and 2 bits otherwise. The next queued frame starts one clock after the stop interval ends.
- R5: Control bits [3:0] select the bit rate. Codes 0 to 15 give 76800, 75, 100, 150, 200, 300, 400, 600, 800, 1200, 1600, 2400, 3200, 4800, 6400 and 12800. Every bit lasts 16 × (REF_HZ / (16 × rate)) clocks.
- R6: A write to address 1 (data) clears status bit 4 (empty) at the next clock. The byte moves to the shift register, and bit 4 is set again, one clock after the transmitter is idle with the byte held. A write while the register is full replaces the held byte.
- R7: Command bits [3:2] set the mode: 00 is off, 01 is on, 10 is off with rts_n held at 0, and 11 is break. A held byte is loaded only in mode 01. While no frame is running and no break is selected, txd stays at 1. rts_n is 1 only in mode 00.
- R8: Mode 11 drives txd to 0 from the clock after the command write until the mode changes.
- R9: Status bit 7 and the active-low irq_n report a pending interrupt. One is pending when the holding register is empty, the mode is 01 and command bit 1 is 0.
- R10: A write of any value to address 0 aborts any frame and empties the holding register. It also clears the command register. From the next clock on, txd is 1, status reads 8'h10 and rts_n is 1. The control register keeps its value.
- R11: dtr_n is the inverse of command bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, REF_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 data, 2 control, 3 command |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (status only) |
| txd | output | 1 | Serial output line, idles high |
| irq_n | output | 1 | Interrupt request, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |

## Verification
A table of bytes with different word lengths, parity kinds and rates is sent, and every data bit, parity bit and first stop bit is sampled at mid-bit. This separates shift order, masking of unused bits and each of the four parity rules. Back-to-back all-ones frames are timed from one start edge to the next, which tells apart the 1, 1.5 and 2 stop-bit cases, including the 8-bit-with-parity exception. The length of the start bit at four rate codes, from the fastest to the slowest, checks the divisor table. Directed sequences cover replacement of a held byte, the off, RTS-only and break modes, interrupt masking, and a programmed reset in the middle of a frame followed by a frame that proves the control register was kept.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    TXM_OFF     = 2'b00,
    TXM_ON      = 2'b01,
    TXM_OFF_RTS = 2'b10,
    TXM_BREAK   = 2'b11
  } txmode_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } parsel_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    parsel_e    par_sel;
    logic [2:0] stop_halves;
    logic [3:0] rate;
  } frame_cfg_t;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CTL  = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  function automatic int unsigned rate_hz(input logic [3:0] code);
    int unsigned r;
    case (code)
      4'd0:    r = 76800;
      4'd1:    r = 75;
      4'd2:    r = 100;
      4'd3:    r = 150;
      4'd4:    r = 200;
      4'd5:    r = 300;
      4'd6:    r = 400;
      4'd7:    r = 600;
      4'd8:    r = 800;
      4'd9:    r = 1200;
      4'd10:   r = 1600;
      4'd11:   r = 2400;
      4'd12:   r = 3200;
      4'd13:   r = 4800;
      4'd14:   r = 6400;
      default: r = 12800;
    endcase
    return r;
  endfunction

  function automatic int unsigned div_for(input int unsigned ref_hz, input logic [3:0] code);
    return ref_hz / (16 * rate_hz(code));
  endfunction

endpackage

// File: rtl/ser_tx_cfg_decode.sv
module ser_tx_cfg_decode
  import ser_tx_pkg::*;
(
  input  logic [7:0] ctl,
  input  logic [7:0] cmd,
  output frame_cfg_t cfg,
  output txmode_e    mode,
  output logic       irq_off,
  output logic       dtr_on
);
  logic unused_bits;
  assign unused_bits = ^{ctl[4], cmd[4]};

  always_comb begin
    cfg.nbits   = 4'd8 - {2'b00, ctl[6:5]};
    cfg.par_en  = cmd[5];
    cfg.par_sel = parsel_e'(cmd[7:6]);
    cfg.rate    = ctl[3:0];
    if (!ctl[7])                          cfg.stop_halves = 3'd2;
    else if (ctl[6:5] == 2'b11)           cfg.stop_halves = 3'd3;
    else if (ctl[6:5] == 2'b00 && cmd[5]) cfg.stop_halves = 3'd2;
    else                                  cfg.stop_halves = 3'd4;
  end

  assign mode    = txmode_e'(cmd[3:2]);
  assign irq_off = cmd[1];
  assign dtr_on  = cmd[0];
endmodule

// File: rtl/ser_tx_baud.sv
module ser_tx_baud
  import ser_tx_pkg::*;
#(
  parameter int unsigned REF_HZ = 1228800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] rate_code,
  output logic       tick
);
  localparam int unsigned MAX_DIV = REF_HZ / (16 * 75);
  localparam int CNT_W = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] div_tab [16];
  logic [CNT_W-1:0] cnt, div_sel, last;

  for (genvar g = 0; g < 16; g++) begin : g_div
    assign div_tab[g] = CNT_W'(div_for(REF_HZ, 4'(g)));
  end

  assign div_sel = div_tab[rate_code];
  assign last    = div_sel - 1'b1;
  assign tick    = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div_sel)); // R5
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       load,
  input  logic [7:0] load_data,
  input  frame_cfg_t load_cfg,
  input  logic       tick,
  output logic       busy,
  output logic       line,
  output logic [3:0] cur_rate
);
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} st_e;

  st_e        state;
  logic [7:0] sh;
  logic [2:0] bitn;
  logic [3:0] sub;
  logic [5:0] stopc;
  frame_cfg_t cfg_q;
  logic       par_q;

  logic [7:0] mask;
  logic       ones_odd, par_next, last_bit, stop_end;

  assign mask     = 8'hFF >> (4'd8 - load_cfg.nbits);
  assign ones_odd = ^(load_data & mask);

  always_comb begin
    case (load_cfg.par_sel)
      PAR_ODD:  par_next = ~ones_odd;
      PAR_EVEN: par_next = ones_odd;
      PAR_MARK: par_next = 1'b1;
      default:  par_next = 1'b0;
    endcase
  end

  assign last_bit = (bitn == 3'(cfg_q.nbits - 4'd1));
  assign stop_end = (stopc == ({cfg_q.stop_halves, 3'b000} - 6'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      bitn  <= '0;
      sub   <= '0;
      stopc <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE;
      sub   <= '0;
      stopc <= '0;
    end else if (load && state == ST_IDLE) begin
      state <= ST_START;
      sh    <= load_data & mask;
      cfg_q <= load_cfg;
      par_q <= par_next;
      sub   <= '0;
      bitn  <= '0;
      stopc <= '0;
    end else if (tick) begin
      case (state)
        ST_START: begin
          sub <= sub + 4'd1;
          if (sub == 4'd15) state <= ST_DATA;
        end
        ST_DATA: begin
          sub <= sub + 4'd1;
          if (sub == 4'd15) begin
            sh   <= sh >> 1;
            bitn <= bitn + 3'd1;
            if (last_bit) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          sub <= sub + 4'd1;
          if (sub == 4'd15) state <= ST_STOP;
        end
        ST_STOP: begin
          stopc <= stopc + 6'd1;
          if (stop_end) begin
            state <= ST_IDLE;
            stopc <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign cur_rate = cfg_q.rate;

  AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort && !busy) |=> (busy && !line)); // R2
  AST_END_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(abort)) |-> ($past(state) == ST_STOP)); // R4
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int unsigned REF_HZ = 1228800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txd,
  output logic       irq_n,
  output logic       rts_n,
  output logic       dtr_n
);
  logic [7:0] ctl_q, cmd_q, hold_q;
  logic       hold_full;
  frame_cfg_t cfg;
  txmode_e    mode;
  logic       irq_off, dtr_on;
  logic       wr_stat, wr_data, load, tick, sh_busy, sh_line;
  logic [3:0] cur_rate;
  logic       tx_empty, pending;
  logic [7:0] status;

  assign wr_stat = reg_we && (reg_addr == A_STAT);
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign load    = !sh_busy && hold_full && (mode == TXM_ON) && !wr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cmd_q     <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTL) ctl_q <= reg_wdata;
      if (wr_stat)                          cmd_q <= '0;
      else if (reg_we && reg_addr == A_CMD) cmd_q <= reg_wdata;
      if (wr_stat) begin
        hold_full <= 1'b0;
      end else if (wr_data) begin
        hold_q    <= reg_wdata;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
    end
  end

  ser_tx_cfg_decode u_dec (
    .ctl     (ctl_q),
    .cmd     (cmd_q),
    .cfg     (cfg),
    .mode    (mode),
    .irq_off (irq_off),
    .dtr_on  (dtr_on)
  );

  ser_tx_baud #(.REF_HZ(REF_HZ)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (sh_busy),
    .rate_code (cur_rate),
    .tick      (tick)
  );

  ser_tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (wr_stat),
    .load      (load),
    .load_data (hold_q),
    .load_cfg  (cfg),
    .tick      (tick),
    .busy      (sh_busy),
    .line      (sh_line),
    .cur_rate  (cur_rate)
  );

  assign tx_empty  = !hold_full;
  assign pending   = tx_empty && (mode == TXM_ON) && !irq_off;
  assign status    = {pending, 2'b00, tx_empty, 4'b0000};
  assign reg_rdata = (reg_addr == A_STAT) ? status : 8'h00;
  assign txd       = (mode == TXM_BREAK) ? 1'b0 : sh_line;
  assign irq_n     = !pending;
  assign rts_n     = (mode == TXM_OFF);
  assign dtr_n     = !dtr_on;

  AST_BREAK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && reg_wdata[3:2] == 2'b11) |=> !txd); // R8
  AST_DATA_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tx_empty); // R6
  AST_PRESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (txd && tx_empty && irq_n && rts_n)); // R10
  AST_NO_START_UNLESS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_busy && mode != TXM_ON) |=> !sh_busy); // R7
endmodule

// File: tb/tb_ser_tx_top.sv
module tb_ser_tx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       txd, irq_n, rts_n, dtr_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_tx_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd),
    .irq_n(irq_n), .rts_n(rts_n), .dtr_n(dtr_n)
  );

  // {control, command, data}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h04, 8'hA5},
    {8'h20, 8'h24, 8'h5A},
    {8'h40, 8'h64, 8'h3C},
    {8'h60, 8'hA4, 8'hFF},
    {8'h0F, 8'hE4, 8'h81},
    {8'h2E, 8'h64, 8'h7F},
    {8'h80, 8'h24, 8'h00},
    {8'h4D, 8'h44, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bdiv(input logic [3:0] c);
    int r;
    case (c)
      4'd0: r = 76800;  4'd1: r = 75;    4'd2: r = 100;   4'd3: r = 150;
      4'd4: r = 200;    4'd5: r = 300;   4'd6: r = 400;   4'd7: r = 600;
      4'd8: r = 800;    4'd9: r = 1200;  4'd10: r = 1600; 4'd11: r = 2400;
      4'd12: r = 3200;  4'd13: r = 4800; 4'd14: r = 6400; default: r = 12800;
    endcase
    return 76800 / r;
  endfunction

  function automatic int nb_of(input logic [7:0] c);
    return 8 - int'(c[6:5]);
  endfunction

  function automatic int halves_of(input logic [7:0] c, input logic [7:0] m);
    if (!c[7]) return 2;
    if (c[6:5] == 2'b11) return 3;
    if (c[6:5] == 2'b00 && m[5]) return 2;
    return 4;
  endfunction

  function automatic logic par_of(input logic [7:0] m, input logic [7:0] d, input int nb);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    case (m[7:6])
      2'b00:   return (ones % 2) == 0;
      2'b01:   return (ones % 2) == 1;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 60000 && txd !== 1'b0; i++) @(negedge clk);
  endtask

  task automatic rx_frame(input int dv, input int nb, input bit pe, input bit find,
                          input int already, output logic [7:0] d, output logic p,
                          output logic stp, output logic st0);
    if (find) wait_start();
    repeat (8 * dv - already) @(negedge clk);
    st0 = txd;
    d = 8'h00;
    for (int i = 0; i < nb; i++) begin
      repeat (16 * dv) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b0;
    if (pe) begin
      repeat (16 * dv) @(negedge clk);
      p = txd;
    end
    repeat (16 * dv) @(negedge clk);
    stp = txd;
  endtask

  task automatic gap_len(input logic [7:0] c, input logic [7:0] m, output int g);
    bit seen_high = 1'b0;
    wr(2'd0, 8'h00); wr(2'd2, c); wr(2'd3, m); wr(2'd1, 8'hFF);
    wait_start();
    wr(2'd1, 8'hFF);
    g = 2;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      g++;
      if (txd) seen_high = 1'b1;
      else if (seen_high) break;
    end
  endtask

  task automatic start_len(input logic [3:0] code, input bit reprogram, output int len);
    if (reprogram) begin
      wr(2'd0, 8'h00); wr(2'd2, {4'h0, code});
    end
    wr(2'd3, 8'h04); wr(2'd1, 8'hFF);
    wait_start();
    len = 0;
    for (int i = 0; i < 70000 && txd == 1'b0; i++) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    logic p, stp, st0;
    int g, len;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 8'h10, "R1 status", v, 8'h10);
    rd(2'd2, v); chk(v == 8'h00, "R1 other addr", v, 8'h00);
    chk({txd, irq_n, rts_n, dtr_n} == 4'hF, "R1 pins", {txd, irq_n, rts_n, dtr_n}, 4'hF);

    // Vector table: R2 framing, R3 parity, R4 stop level, R5 rate
    for (int k = 0; k < 8; k++) begin
      logic [7:0] c, m, dat;
      int nb, dv;
      {c, m, dat} = VEC[k];
      nb = nb_of(c);
      dv = bdiv(c[3:0]);
      wr(2'd2, c); wr(2'd3, m); wr(2'd1, dat);
      rx_frame(dv, nb, m[5], 1'b1, 0, d, p, stp, st0);
      chk(st0 == 1'b0, "R2 start bit", st0, 0);
      chk(d == (dat & 8'(8'hFF >> (8 - nb))), "R2 data bits", d, dat & 8'(8'hFF >> (8 - nb)));
      if (m[5]) chk(p == par_of(m, dat, nb), "R3 parity bit", p, par_of(m, dat, nb));
      chk(stp == 1'b1, "R4 stop level", stp, 1);
    end

    // R6/R9/R11 empty-flag timing and interrupt
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h05);
    chk(dtr_n == 1'b0, "R11 dtr low", dtr_n, 0);
    wr(2'd1, 8'hC3);
    rd(2'd0, v); chk(v == 8'h00, "R6 empty cleared by write", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); chk(v == 8'h90, "R6 R9 empty set at load", v, 8'h90);
    chk(txd == 1'b0, "R6 start at load", txd, 0);
    chk(irq_n == 1'b0, "R9 irq asserted", irq_n, 0);
    wr(2'd3, 8'h06);
    chk(irq_n == 1'b1, "R9 irq masked", irq_n, 1);
    rd(2'd0, v); chk(v == 8'h10, "R9 status masked", v, 8'h10);
    chk(dtr_n == 1'b1, "R11 dtr high", dtr_n, 1);

    // R6 replacement of held byte
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h04);
    wr(2'd1, 8'h11); wr(2'd1, 8'h22);
    rd(2'd0, v); chk(v[4] == 1'b0, "R6 held not empty", v, 8'h00);
    wr(2'd1, 8'h33);
    rx_frame(1, 8, 1'b0, 1'b0, 3, d, p, stp, st0);
    chk(d == 8'h11, "R6 first frame", d, 8'h11);
    rx_frame(1, 8, 1'b0, 1'b1, 0, d, p, stp, st0);
    chk(d == 8'h33, "R6 replaced byte sent", d, 8'h33);

    // R4 stop lengths via start-to-start spacing
    gap_len(8'hE0, 8'h04, g); chk(g == 16 * 6 + 24 + 1, "R4 5-bit 1.5 stop", g, 121);
    gap_len(8'h80, 8'hA4, g); chk(g == 16 * 10 + 16 + 1, "R4 8-bit parity 1 stop", g, 177);
    gap_len(8'hA0, 8'h04, g); chk(g == 16 * 8 + 32 + 1, "R4 7-bit 2 stop", g, 161);
    gap_len(8'h40, 8'h04, g); chk(g == 16 * 7 + 16 + 1, "R4 6-bit 1 stop", g, 129);

    // R5 bit-rate codes
    start_len(4'd0, 1'b1, len);  chk(len == 16 * bdiv(4'd0), "R5 code 0", len, 16 * bdiv(4'd0));
    start_len(4'd12, 1'b1, len); chk(len == 16 * bdiv(4'd12), "R5 code 12", len, 16 * bdiv(4'd12));
    start_len(4'd9, 1'b1, len);  chk(len == 16 * bdiv(4'd9), "R5 code 9", len, 16 * bdiv(4'd9));
    start_len(4'd1, 1'b1, len);  chk(len == 16 * bdiv(4'd1), "R5 code 1", len, 16 * bdiv(4'd1));

    // R10 programmed reset mid-frame
    wr(2'd0, 8'h5A);
    chk(txd == 1'b1, "R10 line high", txd, 1);
    rd(2'd0, v); chk(v == 8'h10, "R10 status", v, 8'h10);
    chk(rts_n == 1'b1, "R10 command cleared", rts_n, 1);
    start_len(4'd1, 1'b0, len);
    chk(len == 16 * bdiv(4'd1), "R10 control kept", len, 16 * bdiv(4'd1));
    wr(2'd0, 8'h00);

    // R7 modes
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h96);
    len = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!txd) len++; end
    chk(len == 0, "R7 off idles high", len, 0);
    chk(rts_n == 1'b1, "R7 rts off", rts_n, 1);
    rd(2'd0, v); chk(v == 8'h00, "R7 byte held when off", v, 8'h00);
    wr(2'd3, 8'h08);
    chk(rts_n == 1'b0, "R7 rts kept", rts_n, 0);
    len = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!txd) len++; end
    chk(len == 0, "R7 rts-only no send", len, 0);
    wr(2'd3, 8'h04);
    rx_frame(1, 8, 1'b0, 1'b1, 0, d, p, stp, st0);
    chk(d == 8'h96, "R7 held byte sent when on", d, 8'h96);

    // R8 break
    wr(2'd0, 8'h00); wr(2'd3, 8'h0C);
    chk(txd == 1'b0, "R8 break low", txd, 0);
    len = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd) len++; end
    chk(len == 0, "R8 break held", len, 0);
    chk(rts_n == 1'b0, "R8 rts in break", rts_n, 0);
    wr(2'd3, 8'h04);
    chk(txd == 1'b1, "R8 break released", txd, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule